// File: doc/BRIEF.md
# Bus Stuck-Low and Buffer-Space Error Monitor

This block watches the clock and data lines of a two-wire serial bus, along with the occupancy of a byte-addressed receive ring buffer. It raises four sticky error flags. Each bus line has its own counter of consecutive low samples, and that counter is compared against a limit that firmware programs. A line that stays low longer than its limit is reported once for each stuck-low episode.

The ring buffer is described by a write pointer, a read pointer and a size. Free space is derived from these with one byte always kept unused, so that an empty buffer and a full buffer can be told apart. The almost-full check runs only when a memory write completes. The full check runs each time a write is requested, and compares the requested length with the free space.

Status bits are cleared by writing a one to them. Each flag also has a one-cycle event pulse, which surrounding logic can use to schedule an interrupt.

Top module: `bus_err_monitor`

## Requirements
- R1: Status bit 0 (clock timeout) is set when `scl_in` has been sampled low on more than `scl_limit` consecutive clock edges. With limit L, it is set after the edge that takes the (L+1)th consecutive low sample.
- R2: Status bit 1 (data timeout) follows the R1 rule for `sda_in` against its own limit `sda_limit`, independently of the clock line.
- R3: A high sample restarts a line's low count. One stuck-low episode produces exactly one event pulse, however long the line stays low.
- R4: Free space equals (`buf_size` - 1) minus ((`wr_ptr` - `rd_ptr`) modulo `buf_size`).
- R5: Status bit 2 (almost full) is set in the cycle after `wr_done` is high and free space is below 85 bytes. When `wr_done` is low, the condition is not evaluated.
- R6: Status bit 3 (full) is set in the cycle after `wr_req` is high and `wr_len` exceeds the free space. When `wr_req` is low, the condition is not evaluated.
- R7: Status bits are sticky. A cycle with `clr_wr` high clears each bit whose `clr_data` bit is 1. Bits written with 0 are unchanged.
- R8: A set event for a bit in the same cycle as a clear of that bit leaves the bit set.
- R9: `evt_pulse[i]` is high for exactly the cycle in which the set event for bit i is first reflected in `status`.
- R10: After reset, `status` and `evt_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Synchronized bus clock line level |
| sda_in | input | 1 | Synchronized bus data line level |
| scl_limit | input | CNT_W | Allowed consecutive low samples, clock line |
| sda_limit | input | CNT_W | Allowed consecutive low samples, data line |
| wr_ptr | input | PTR_W | Ring buffer write pointer (byte index) |
| rd_ptr | input | PTR_W | Ring buffer read pointer (byte index) |
| buf_size | input | PTR_W+1 | Ring buffer size in bytes |
| wr_done | input | 1 | A data or header write has completed |
| wr_req | input | 1 | A write is requested this cycle |
| wr_len | input | PTR_W+1 | Byte length of the requested write |
| clr_wr | input | 1 | Strobe for write-one-to-clear of status |
| clr_data | input | 4 | Per-bit clear mask |
| status | output | 4 | Sticky flags: 0 clock timeout, 1 data timeout, 2 almost full, 3 full |
| evt_pulse | output | 4 | One-cycle set event per flag |

## Verification
The bench checks the off-by-one edges of each comparison:
- A timer that tripped at L low samples, or at L+2, would miss the exact edge checked.
- Free space of exactly 85 versus 84 bytes separates a correct almost-full check from one that uses less-or-equal.
- A requested length equal to the free space must not report full.

Pointer pairs that wrap around the end of the buffer catch a free-space formula that forgets the modulo. A design that evaluates almost-full without a completed write would flag a vector with `wr_done` low.

A held-low line exposes a timer that re-fires on every cycle. A clear that coincides with a set exposes a design in which the clear wins.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
  localparam int ST_SCL   = 0;
  localparam int ST_SDA   = 1;
  localparam int ST_AFULL = 2;
  localparam int ST_FULL  = 3;
  localparam int NUM_ST   = 4;
  typedef logic [NUM_ST-1:0] st_vec_t;
endpackage

// File: rtl/busmon_low_timer.sv
module busmon_low_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  input  logic [CNT_W-1:0] limit,
  output logic             trip
);
  localparam int W = CNT_W + 1;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_x;
  logic         sat;

  assign lim_x = {1'b0, limit};
  assign sat   = (cnt_q > lim_x);
  assign trip  = !line_in && (cnt_q == lim_x);

  always_comb begin
    if (line_in)  cnt_d = '0;
    else if (sat) cnt_d = cnt_q;
    else          cnt_d = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busmon_ring_space.sv
module busmon_ring_space #(
  parameter int PTR_W     = 10,
  parameter int ALMOST_TH = 85
) (
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W:0]   buf_size,
  input  logic             wr_done,
  input  logic             wr_req,
  input  logic [PTR_W:0]   wr_len,
  output logic             almost_evt,
  output logic             full_evt
);
  localparam int SZ_W = PTR_W + 1;
  localparam logic [SZ_W-1:0] TH = SZ_W'(ALMOST_TH);

  logic [SZ_W-1:0] diff, used, free_b;

  always_comb begin
    diff = {1'b0, wr_ptr} - {1'b0, rd_ptr};
    if (wr_ptr < rd_ptr) used = diff + buf_size;
    else                 used = diff;
    free_b     = buf_size - {{(SZ_W-1){1'b0}}, 1'b1} - used;
    almost_evt = wr_done && (free_b < TH);
    full_evt   = wr_req && (wr_len > free_b);
  end
endmodule

// File: rtl/busmon_status.sv
module busmon_status
  import busmon_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  st_vec_t set_evt,
  input  logic    clr_wr,
  input  st_vec_t clr_data,
  output st_vec_t status,
  output st_vec_t pulse
);
  st_vec_t st_q, st_d, pl_q, clr_m;
  logic    st_en;

  always_comb begin
    clr_m = clr_wr ? clr_data : '0;
    st_en = (|set_evt) || clr_wr;
    st_d  = (st_q & ~clr_m) | set_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      pl_q <= '0;
    end else begin
      if (st_en) st_q <= st_d;
      pl_q <= set_evt;
    end
  end

  assign status = st_q;
  assign pulse  = pl_q;
endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor
  import busmon_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PTR_W     = 10,
  parameter int ALMOST_TH = 85
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [CNT_W-1:0] scl_limit,
  input  logic [CNT_W-1:0] sda_limit,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [PTR_W-1:0] rd_ptr,
  input  logic [PTR_W:0]   buf_size,
  input  logic             wr_done,
  input  logic             wr_req,
  input  logic [PTR_W:0]   wr_len,
  input  logic             clr_wr,
  input  logic [3:0]       clr_data,
  output logic [3:0]       status,
  output logic [3:0]       evt_pulse
);
  localparam int NLINE = 2;

  st_vec_t           evt;
  logic [NLINE-1:0]  line_lvl;
  logic [CNT_W-1:0]  line_lim [NLINE];
  logic [NLINE-1:0]  line_trip;

  assign line_lvl    = {sda_in, scl_in};
  assign line_lim[0] = scl_limit;
  assign line_lim[1] = sda_limit;

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    busmon_low_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_lvl[g]),
      .limit   (line_lim[g]),
      .trip    (line_trip[g])
    );
  end

  busmon_ring_space #(.PTR_W(PTR_W), .ALMOST_TH(ALMOST_TH)) u_ring (
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .buf_size   (buf_size),
    .wr_done    (wr_done),
    .wr_req     (wr_req),
    .wr_len     (wr_len),
    .almost_evt (evt[ST_AFULL]),
    .full_evt   (evt[ST_FULL])
  );

  assign evt[ST_SCL] = line_trip[0];
  assign evt[ST_SDA] = line_trip[1];

  busmon_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (evt),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .status   (status),
    .pulse    (evt_pulse)
  );
endmodule

// File: rtl/bus_err_monitor_chk.sv
module bus_err_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_in,
  input logic       wr_done,
  input logic       wr_req,
  input logic       clr_wr,
  input logic [3:0] clr_data,
  input logic [3:0] status,
  input logic [3:0] evt_pulse
);
  assert_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[0] |-> $past(!scl_in)) else $error("R1 pulse without low clock line");

  assert_sda_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[1] |-> $past(!sda_in)) else $error("R2 pulse without low data line");

  assert_single_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[0] |=> !evt_pulse[0]) else $error("R3 repeated clock timeout pulse");

  assert_single_sda_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[1] |=> !evt_pulse[1]) else $error("R3 repeated data timeout pulse");

  assert_afull_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[2] |-> $past(wr_done)) else $error("R5 almost-full without completed write");

  assert_full_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[3] |-> $past(wr_req)) else $error("R6 full without write request");

  for (genvar i = 0; i < 4; i++) begin : g_bit
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      status[i] && !(clr_wr && clr_data[i]) |=> status[i]) else $error("R7 status bit dropped");

    assert_pulse_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse[i] |-> status[i]) else $error("R8/R9 pulse without status");
  end
endmodule

bind bus_err_monitor bus_err_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_in    (scl_in),
  .sda_in    (sda_in),
  .wr_done   (wr_done),
  .wr_req    (wr_req),
  .clr_wr    (clr_wr),
  .clr_data  (clr_data),
  .status    (status),
  .evt_pulse (evt_pulse)
);

// File: tb/bus_err_monitor_test.sv
module bus_err_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_in, sda_in;
  logic [15:0] scl_limit, sda_limit;
  logic [9:0]  wr_ptr, rd_ptr;
  logic [10:0] buf_size;
  logic        wr_done, wr_req;
  logic [10:0] wr_len;
  logic        clr_wr;
  logic [3:0]  clr_data;
  logic [3:0]  status, evt_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_err_monitor uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_limit(scl_limit), .sda_limit(sda_limit),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .buf_size(buf_size),
    .wr_done(wr_done), .wr_req(wr_req), .wr_len(wr_len),
    .clr_wr(clr_wr), .clr_data(clr_data),
    .status(status), .evt_pulse(evt_pulse)
  );

  typedef struct packed {
    logic [9:0]  wr;
    logic [9:0]  rd;
    logic        done;
    logic        req;
    logic [10:0] len;
    logic        exp_a;
    logic        exp_f;
  } vec_t;

  // buf_size = 256; free = 255 - ((wr - rd) mod 256)
  localparam vec_t VECS [8] = '{
    '{10'd0,   10'd0,   1'b1, 1'b1, 11'd255, 1'b0, 1'b0}, // free 255
    '{10'd171, 10'd0,   1'b1, 1'b1, 11'd84,  1'b1, 1'b0}, // free 84, len=free
    '{10'd170, 10'd0,   1'b1, 1'b1, 11'd86,  1'b0, 1'b1}, // free 85
    '{10'd10,  10'd20,  1'b0, 1'b1, 11'd10,  1'b0, 1'b1}, // wrap, free 9, no done
    '{10'd10,  10'd20,  1'b1, 1'b0, 11'd200, 1'b1, 1'b0}, // wrap, no req
    '{10'd255, 10'd0,   1'b1, 1'b1, 11'd0,   1'b1, 1'b0}, // free 0, len 0
    '{10'd5,   10'd6,   1'b0, 1'b1, 11'd1,   1'b0, 1'b1}, // wrap, free 0
    '{10'd100, 10'd100, 1'b1, 1'b1, 11'd0,   1'b0, 1'b0}  // empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    scl_in = 1'b1; sda_in = 1'b1;
    wr_done = 1'b0; wr_req = 1'b0; wr_len = '0;
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = 4'hF;
    tick();
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    scl_limit = 16'd3; sda_limit = 16'd5;
    wr_ptr = '0; rd_ptr = '0; buf_size = 11'd256;
    repeat (3) tick();
    chk("R10 status after reset", {28'd0, status}, 32'd0);
    chk("R10 pulse after reset", {28'd0, evt_pulse}, 32'd0);
    rst_n = 1'b1;
    tick();

    // Vector table: R4 free space, R5 almost-full, R6 full
    for (int k = 0; k < 8; k++) begin
      wr_ptr = VECS[k].wr; rd_ptr = VECS[k].rd;
      wr_done = VECS[k].done; wr_req = VECS[k].req; wr_len = VECS[k].len;
      tick();
      chk("R5/R4 almost-full pulse", {31'd0, evt_pulse[2]}, {31'd0, VECS[k].exp_a});
      chk("R6/R4 full pulse", {31'd0, evt_pulse[3]}, {31'd0, VECS[k].exp_f});
      wr_done = 1'b0; wr_req = 1'b0;
      tick();
      chk("R9 pulse one cycle", {28'd0, evt_pulse}, 32'd0);
    end
    clear_all();
    chk("R7 clear all", {28'd0, status}, 32'd0);

    // R1 clock timeout with limit 3
    scl_in = 1'b0;
    repeat (3) tick();
    chk("R1 not yet at limit", {31'd0, status[0]}, 32'd0);
    tick();
    chk("R1 clock timeout set", {31'd0, status[0]}, 32'd1);
    chk("R9 clock pulse", {28'd0, evt_pulse}, 32'd1);
    chk("R2 data untouched", {31'd0, status[1]}, 32'd0);
    repeat (4) tick();
    chk("R3 no repeat pulse", {31'd0, evt_pulse[0]}, 32'd0);
    scl_in = 1'b1;
    tick();
    clr_wr = 1'b1; clr_data = 4'b0001;
    tick();
    clr_wr = 1'b0; clr_data = '0;
    chk("R7 clock bit cleared", {28'd0, status}, 32'd0);
    scl_in = 1'b0;
    repeat (2) tick();
    scl_in = 1'b1;
    tick();
    scl_in = 1'b0;
    repeat (3) tick();
    chk("R3 high sample restarts count", {31'd0, status[0]}, 32'd0);
    tick();
    chk("R3 new episode sets again", {31'd0, evt_pulse[0]}, 32'd1);
    scl_in = 1'b1;
    clear_all();

    // R2 data timeout with limit 5
    sda_in = 1'b0;
    repeat (5) tick();
    chk("R2 not yet at limit", {31'd0, status[1]}, 32'd0);
    tick();
    chk("R2 data timeout set", {28'd0, status}, 32'd2);
    sda_in = 1'b1;
    tick();

    // R7 zero mask has no effect
    clr_wr = 1'b1; clr_data = 4'b1101;
    tick();
    clr_wr = 1'b0; clr_data = '0;
    chk("R7 zero mask bit kept", {28'd0, status}, 32'd2);
    clr_wr = 1'b0; clr_data = 4'b0010;
    tick();
    chk("R7 no strobe no clear", {28'd0, status}, 32'd2);

    // R8 set in the same cycle as clear
    wr_ptr = 10'd5; rd_ptr = 10'd6;
    wr_req = 1'b1; wr_len = 11'd1;
    clr_wr = 1'b1; clr_data = 4'b1010;
    tick();
    wr_req = 1'b0; clr_wr = 1'b0; clr_data = '0;
    chk("R8 set wins over clear", {28'd0, status}, 32'd8);
    tick();
    chk("R7 full bit sticky", {31'd0, status[3]}, 32'd1);

    summary();
  end
endmodule